// File: doc/BRIEF.md
# Cycle-Stealing Counter Update Unit

This block keeps a bank of twenty hardware counters, stored as words in an external counter memory, up to date without any software involvement. Each counter has its own request pulse. A request carries an operation (count up, count down or shift in a bit) and is latched as pending until it can be serviced. The instruction sequencer announces every instruction boundary with a one-cycle pulse. At such a boundary, if any request is pending, the unit takes over for one stolen subsequence. In that subsequence it reads the counter word, modifies it and writes it back, and it holds a busy flag so the sequencer delays the next instruction until the write has finished.

Counter words are 15-bit ones'-complement values. Bit 14 is the sign and bits 13:0 are the magnitude; 15'h0000 is plus zero and 15'h7FFF is minus zero. If counting up passes the largest positive value, or counting down passes the largest negative value, the counter overflows. The counter is then cleared and a per-counter interrupt line pulses, so that downstream logic can decide what to do about it.

The memory port has a fixed timing and no back-pressure. The read strobe is followed one cycle later by the read data, and the write strobe carries the address and the data in the same cycle. The request inputs and the boundary pulse have no ready path. A request made while its counter is already pending is absorbed into the pending request and is not queued a second time.

Top module: `ctr_steal_unit`

## Requirements
- R1: After reset, no request is pending, `steal_active` is low, `mem_rd` and `mem_wr` are low, and `ovf_irq` is all zero.
- R2: A request is latched but not serviced until a `boundary` pulse arrives. With no boundary, no memory access takes place, however long the request stays pending.
- R3: A `boundary` pulse taken while idle with a request pending starts one subsequence. `steal_active` and `mem_rd` rise in the next cycle. `mem_wr` to the same address follows two cycles after `mem_rd`, and `steal_active` falls the cycle after the write. Each boundary pulse services at most one request.
- R4: When several requests are pending, the lowest-numbered counter is serviced first. The memory address of a counter is its number.
- R5: A counter holds at most one pending request. A second request for a counter that is already pending is dropped, along with its operation code and data bit.
- R6: A request for a counter that arrives during that counter's own service is latched and is serviced at a later boundary.
- R7: Operation code 2'b00 counts up with an end-around carry. Minus zero becomes plus one, and a result equal to zero from a nonzero source is written as minus zero (15'h7FFF).
- R8: Operation code 2'b01 counts down in ones'-complement. Plus zero and minus zero both become minus one (15'h7FFE).
- R9: Counting up from 15'h3FFF, or counting down from 15'h4000, writes plus zero. In that case the `ovf_irq` bit of the counter pulses high for exactly the write cycle, and no other bit goes high.
- R10: Operation code 2'b10 writes the word shifted left by one, with the request's data bit in bit 0; bit 14 is discarded. A shift never raises `ovf_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 20 | Per-counter request pulse |
| req_op | input | 40 | Two-bit operation code per counter, counter k at bits 2k+1:2k |
| req_bit | input | 20 | Per-counter data bit for the shift operation |
| boundary | input | 1 | One-cycle instruction-boundary pulse from the sequencer |
| steal_active | output | 1 | High while a stolen subsequence is running |
| mem_rd | output | 1 | Counter memory read strobe |
| mem_wr | output | 1 | Counter memory write strobe |
| mem_addr | output | 5 | Counter number being accessed |
| mem_rdata | input | 15 | Read data, valid the cycle after `mem_rd` |
| mem_wdata | output | 15 | Updated counter word, valid with `mem_wr` |
| ovf_irq | output | 20 | Per-counter overflow interrupt pulse |

## Verification
The assertions assume a counter memory that returns the addressed word exactly one cycle after the read strobe. They also assume the sequencer drives `boundary` only as a pulse, and that operation code 2'b11 is never sent. The bench meets all three. Its memory model is registered with a single cycle of read latency, it raises `boundary` for one cycle at a time, and it draws operation codes only from the three defined values. It sweeps about a thousand word values per operation across all counters and compares each written word and interrupt against an arithmetic ones'-complement model.

// File: rtl/ctr_steal_pkg.sv
package ctr_steal_pkg;
  localparam int WORD_W = 15;

  typedef enum logic [1:0] {
    OP_INC = 2'b00,
    OP_DEC = 2'b01,
    OP_SHL = 2'b10
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_MODIFY,
    ST_WRITE
  } steal_st_e;
endpackage

// File: rtl/ctr_pending.sv
module ctr_pending #(
  parameter int N = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_valid,
  input  logic [2*N-1:0] req_op,
  input  logic [N-1:0]   req_bit,
  input  logic [N-1:0]   clr_mask,
  output logic [N-1:0]   pend,
  output logic [2*N-1:0] pend_op,
  output logic [N-1:0]   pend_bit
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic take;
    assign take = req_valid[g] && (!pend[g] || clr_mask[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g]          <= 1'b0;
        pend_op[2*g +: 2] <= 2'b00;
        pend_bit[g]      <= 1'b0;
      end else if (take) begin
        pend[g]          <= 1'b1;
        pend_op[2*g +: 2] <= req_op[2*g +: 2];
        pend_bit[g]      <= req_bit[g];
      end else if (clr_mask[g]) begin
        pend[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctr_lowest_pick.sv
module ctr_lowest_pick #(
  parameter int N  = 20,
  parameter int IW = 5
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
    any = |pend;
  end
endmodule

// File: rtl/ctr_ones_alu.sv
module ctr_ones_alu
  import ctr_steal_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  op_e               op,
  input  logic              ins_bit,
  output logic [WORD_W-1:0] word_out,
  output logic              ovf
);
  logic [WORD_W-1:0] addend;
  logic [WORD_W:0]   sum;
  logic [WORD_W-1:0] folded;
  logic              wrap;

  always_comb begin
    addend = (op == OP_DEC) ? {{(WORD_W-1){1'b1}}, 1'b0}
                            : {{(WORD_W-1){1'b0}}, 1'b1};
    sum    = {1'b0, word_in} + {1'b0, addend};
    folded = sum[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, sum[WORD_W]};
    wrap   = (word_in[WORD_W-1] == addend[WORD_W-1]) &&
             (folded[WORD_W-1] != word_in[WORD_W-1]);
    if (op == OP_SHL) begin
      word_out = {word_in[WORD_W-2:0], ins_bit};
      ovf      = 1'b0;
    end else begin
      word_out = wrap ? '0 : folded;
      ovf      = wrap;
    end
  end
endmodule

// File: rtl/ctr_steal_unit.sv
module ctr_steal_unit
  import ctr_steal_pkg::*;
#(
  parameter int N  = 20,
  parameter int AW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_valid,
  input  logic [2*N-1:0]    req_op,
  input  logic [N-1:0]      req_bit,
  input  logic              boundary,
  output logic              steal_active,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [N-1:0]      ovf_irq
);
  steal_st_e         st;
  logic [N-1:0]      pend;
  logic [2*N-1:0]    pend_op;
  logic [N-1:0]      pend_bit;
  logic [N-1:0]      clr_mask;
  logic              any_pend;
  logic [AW-1:0]     pick;
  logic              grant;
  logic [AW-1:0]     idx_q;
  op_e               op_q;
  logic              bit_q;
  logic [WORD_W-1:0] res_q;
  logic              ovf_q;
  logic [WORD_W-1:0] alu_out;
  logic              alu_ovf;

  assign grant    = (st == ST_IDLE) && boundary && any_pend;
  assign clr_mask = grant ? (N'(1) << pick) : '0;

  ctr_pending #(.N(N)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit),
    .clr_mask(clr_mask),
    .pend(pend), .pend_op(pend_op), .pend_bit(pend_bit)
  );

  ctr_lowest_pick #(.N(N), .IW(AW)) u_pick (
    .pend(pend), .any(any_pend), .idx(pick)
  );

  ctr_ones_alu u_alu (
    .word_in(mem_rdata), .op(op_q), .ins_bit(bit_q),
    .word_out(alu_out), .ovf(alu_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx_q <= '0;
      op_q  <= OP_INC;
      bit_q <= 1'b0;
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (grant) begin
          st    <= ST_READ;
          idx_q <= pick;
          op_q  <= op_e'(pend_op[2*pick +: 2]);
          bit_q <= pend_bit[pick];
        end
        ST_READ:   st <= ST_MODIFY;
        ST_MODIFY: begin
          res_q <= alu_out;
          ovf_q <= alu_ovf;
          st    <= ST_WRITE;
        end
        ST_WRITE:  st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign steal_active = (st != ST_IDLE);
  assign mem_rd       = (st == ST_READ);
  assign mem_wr       = (st == ST_WRITE);
  assign mem_addr     = idx_q;
  assign mem_wdata    = res_q;
  assign ovf_irq      = (mem_wr && ovf_q) ? (N'(1) << idx_q) : '0;
endmodule

// File: rtl/ctr_steal_chk.sv
module ctr_steal_chk #(
  parameter int N  = 20,
  parameter int AW = 5,
  parameter int W  = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boundary,
  input logic          steal_active,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [W-1:0]  mem_wdata,
  input logic [N-1:0]  ovf_irq
);
  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ##1 (mem_wr && mem_addr == $past(mem_addr, 2)));

  // R3
  start_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steal_active) |-> $past(boundary));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R3
  end_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !steal_active);

  // R9
  irq_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_irq) |-> (mem_wr && $countones(ovf_irq) == 1 && ovf_irq[mem_addr]));

  // R9
  irq_clears_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_irq) |-> (mem_wdata == '0));

  // R1
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !steal_active |-> (ovf_irq == '0 && !mem_rd));
endmodule

bind ctr_steal_unit ctr_steal_chk #(.N(N), .AW(AW), .W(ctr_steal_pkg::WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .steal_active(steal_active),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .ovf_irq(ovf_irq)
);

// File: tb/ctr_steal_unit_tb.sv
module ctr_steal_unit_tb;
  localparam int N = 20;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [2*N-1:0] req_op = '0;
  logic [N-1:0] req_bit = '0;
  logic boundary = 1'b0;
  logic steal_active, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [14:0] mem_rdata, mem_wdata;
  logic [N-1:0] ovf_irq;

  logic [14:0] mem [0:N-1];
  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [AW-1:0] last_addr;
  logic [14:0] last_data;
  logic [N-1:0] last_irq;

  always #5 clk = ~clk;

  ctr_steal_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bit(req_bit), .boundary(boundary), .steal_active(steal_active),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .ovf_irq(ovf_irq)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt    <= wr_cnt + 1;
      last_addr <= mem_addr;
      last_data <= mem_wdata;
      last_irq  <= ovf_irq;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input int op, input logic [14:0] v, input logic b,
                                output logic [14:0] res, output logic ovf);
    int m;
    ovf = 1'b0;
    if (op == 2) begin
      res = {v[13:0], b};
    end else begin
      m = v[14] ? -int'((~v) & 15'h7FFF) : int'(v);
      m = m + ((op == 0) ? 1 : -1);
      if (m > 16383 || m < -16383) begin
        res = 15'h0000; ovf = 1'b1;
      end else if (m == 0) res = 15'h7FFF;
      else if (m > 0) res = 15'(m);
      else res = (~15'(-m)) & 15'h7FFF;
    end
  endfunction

  task automatic pulse_req(input int idx, input int op, input logic b);
    req_valid[idx] = 1'b1;
    req_op[2*idx +: 2] = 2'(op);
    req_bit[idx] = b;
    @(negedge clk);
    req_valid = '0;
  endtask

  task automatic pulse_boundary();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic svc(input string req, input int idx, input int op,
                     input logic b, input logic [14:0] v);
    logic [14:0] er;
    logic eo;
    int w0;
    mem[idx] = v;
    w0 = wr_cnt;
    pulse_req(idx, op, b);
    pulse_boundary();
    model(op, v, b, er, eo);
    chk({req, " write count"}, wr_cnt, w0 + 1);
    chk({req, " addr"}, int'(last_addr), idx);
    chk({req, " word"}, int'(last_data), int'(er));
    chk({req, " irq"}, int'(last_irq), eo ? (1 << idx) : 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int w0;
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 steal_active", int'(steal_active), 0);
    chk("R1 mem_rd", int'(mem_rd), 0);
    chk("R1 mem_wr", int'(mem_wr), 0);
    chk("R1 ovf_irq", int'(ovf_irq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    w0 = wr_cnt;
    boundary = 1'b1; @(negedge clk); boundary = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 nothing pending", wr_cnt, w0);

    // R2 no boundary, no service
    mem[4] = 15'd7;
    w0 = wr_cnt;
    pulse_req(4, 0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R2 no write", wr_cnt, w0);
    chk("R2 idle", int'(steal_active), 0);
    // R3 cycle timing
    boundary = 1'b1; @(negedge clk); boundary = 1'b0;
    chk("R3 active", int'(steal_active), 1);
    chk("R3 rd", int'(mem_rd), 1);
    chk("R3 addr", int'(mem_addr), 4);
    @(negedge clk);
    chk("R3 gap", int'({mem_rd, mem_wr}), 0);
    @(negedge clk);
    chk("R3 wr", int'(mem_wr), 1);
    chk("R3 wr addr", int'(mem_addr), 4);
    @(negedge clk);
    chk("R3 end", int'(steal_active), 0);
    chk("R2 served", int'(mem[4]), 8);

    // corners
    svc("R9 inc max", 0, 0, 1'b0, 15'h3FFF);
    svc("R9 dec min", 19, 1, 1'b0, 15'h4000);
    svc("R7 inc -0", 6, 0, 1'b0, 15'h7FFF);
    svc("R7 inc -1", 7, 0, 1'b0, 15'h7FFE);
    svc("R8 dec +0", 8, 1, 1'b0, 15'h0000);
    svc("R8 dec -0", 9, 1, 1'b0, 15'h7FFF);
    svc("R10 shift", 10, 2, 1'b1, 15'h4001);

    // sweeps
    for (int op = 0; op < 3; op++) begin
      for (int i = 0; i < 1024; i++) begin
        logic [14:0] v;
        v = 15'((i * 32 + (i % 32)) & 32'h7FFF);
        case (op)
          0: svc("R7 sweep", i % N, op, 1'(i), v);
          1: svc("R8 sweep", i % N, op, 1'(i), v);
          default: svc("R10 sweep", i % N, op, 1'(i), v);
        endcase
      end
    end

    // R4 priority
    req_valid[17] = 1'b1; req_op[35:34] = 2'b00;
    req_valid[3] = 1'b1;  req_op[7:6] = 2'b00;
    req_valid[9] = 1'b1;  req_op[19:18] = 2'b00;
    @(negedge clk);
    req_valid = '0;
    pulse_boundary();
    chk("R4 first", int'(last_addr), 3);
    pulse_boundary();
    chk("R4 second", int'(last_addr), 9);
    pulse_boundary();
    chk("R4 third", int'(last_addr), 17);

    // R5 duplicate dropped
    mem[5] = 15'd10;
    w0 = wr_cnt;
    pulse_req(5, 0, 1'b0);
    pulse_req(5, 1, 1'b0);
    pulse_boundary();
    chk("R5 first op kept", int'(mem[5]), 11);
    pulse_boundary();
    chk("R5 one write", wr_cnt, w0 + 1);

    // R6 request during own service
    mem[2] = 15'd20;
    w0 = wr_cnt;
    pulse_req(2, 0, 1'b0);
    boundary = 1'b1; @(negedge clk); boundary = 1'b0;
    pulse_req(2, 0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R6 first", int'(mem[2]), 21);
    pulse_boundary();
    chk("R6 second", int'(mem[2]), 22);
    chk("R6 writes", wr_cnt, w0 + 2);

    finish_run();
  end
endmodule